// File: doc/BRIEF.md
# Memory Scrub Controller

This block walks every codeword of a memory array, one step at a time, to find and repair latent single-bit errors. In each step it issues a read through an external request/grant port. The read data arrives already passed through the ECC decoder, together with a flag that says a single-bit error was corrected. When that flag is set, the step issues a second access that writes the corrected word back to the same address. A clean codeword costs one access and an errored one costs two.

Steps come from one of two sources. In command-driven mode, each pulse on a command input starts one step. In self-paced mode, an internal interval counter issues step tokens at a programmable cycle spacing. Software sets that spacing so that a whole pass over the array fits inside the target scrub period, such as one day. Tokens that arrive while the engine is busy are queued and are not lost.

When the last codeword of the array has been handled, the engine publishes two statistics for the pass. The first is the total number of corrected codewords. The second is the row that held the most of them. Each statistic is gated by its own threshold. The published values stay fixed until the next pass ends.

Top module: `scrub_engine`

## Requirements
- R1: While reset is asserted, and until the first step starts, mem_req, pass_done and rep_row_hit are 0, and rep_total, rep_row and rep_row_cnt are 0.
- R2: Steps visit codewords in the order column 0..COLS-1 within a row and then the next row, wrapping from the last codeword to row 0 column 0. pass_done is high for exactly one cycle after the step on the last codeword completes.
- R3: Each step reads its codeword (mem_we=0). If mem_ecc_err is 1 in the cycle the read is granted, the engine then writes the granted mem_rdata back to the same address (mem_we=1). Otherwise it makes no write.
- R4: An access holds mem_req high, with address and mem_we unchanged, until mem_gnt is seen.
- R5: With auto_en=0, a manual_go pulse seen while no step is in progress starts exactly one step. A pulse seen while a step is in progress, or while auto_en=1, is ignored.
- R6: With auto_en=1, a step token is issued every max(step_interval,1) cycles, counted from the enable. With immediate grants, consecutive step reads are therefore step_interval cycles apart.
- R7: In self-paced mode, tokens that arrive while a step is busy are queued, up to 2^PEND_W-1 of them. Every queued token later runs a step.
- R8: The pass total counts corrected codewords and saturates at 2^TOT_W-1. At pass end, rep_total is set to the total if it is strictly greater than total_thresh, and to 0 otherwise.
- R9: The per-row count saturates at 2^ROWC_W-1. At pass end, the worst row is the first row whose count is strictly greater than that of every earlier row. If its count is strictly greater than row_thresh, then rep_row_hit=1 and rep_row and rep_row_cnt give that row and its count. Otherwise all three are 0.
- R10: All counts restart from zero for each new pass. rep_total, rep_row, rep_row_cnt and rep_row_hit change only in the cycle where pass_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | 1 = self-paced mode, 0 = command-driven mode |
| manual_go | input | 1 | Step command pulse in command-driven mode |
| step_interval | input | IVL_W | Cycles between self-paced step tokens |
| total_thresh | input | TOT_W | Reporting threshold for the pass total |
| row_thresh | input | ROWC_W | Reporting threshold for the worst-row count |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write-back access, 0 = read access |
| mem_row | output | clog2(ROWS) | Row of the access |
| mem_col | output | clog2(COLS) | Codeword within the row |
| mem_wdata | output | DATA_W | Corrected data for write-back |
| mem_gnt | input | 1 | Access granted this cycle |
| mem_rdata | input | DATA_W | Decoded read data, valid with the read grant |
| mem_ecc_err | input | 1 | A single-bit error was corrected, valid with the read grant |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |
| rep_total | output | TOT_W | Reported corrected-codeword total |
| rep_row | output | clog2(ROWS) | Reported worst row |
| rep_row_cnt | output | ROWC_W | Reported worst-row count |
| rep_row_hit | output | 1 | Worst-row report is above its threshold |

## Verification
The engine runs over a small 4x4 array using several error maps. The maps are: errors spread over three rows with a unique worst row, errors in every codeword, one error in each of two rows, and three errors packed into the last row. Together they separate saturation from plain counting and strict-greater from greater-or-equal at both thresholds. They also check the first-row-wins rule on ties and the zeroed report below threshold. Manual passes use delayed grants and doubled command pulses, so that a dropped step and an extra step show up as address-order and access-count errors. Self-paced runs use immediate grants to measure the step spacing. Slow grants build up a queue of tokens, and the number of steps that run is compared with the number of tokens issued.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WBACK = 2'd2
  } step_st_e;

endpackage

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
  parameter int IVL_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_en,
  input  logic [IVL_W-1:0] step_interval,
  input  logic             take,
  output logic             pend
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [IVL_W-1:0]  cnt_q, cnt_d;
  logic [IVL_W:0]    cnt_inc;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              tick;

  // interval counter: one token every max(step_interval,1) cycles
  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{IVL_W{1'b0}}, 1'b1};
    tick    = 1'b0;
    cnt_d   = cnt_q;
    if (!auto_en) begin
      cnt_d = '0;
    end else if (cnt_inc >= {1'b0, step_interval}) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[IVL_W-1:0];
    end
  end

  // token queue: tick adds, take removes, saturates at the top
  always_comb begin
    pend_d = pend_q;
    if (!auto_en) begin
      pend_d = '0;
    end else if (tick && !take) begin
      if (pend_q != PEND_MAX) pend_d = pend_q + 1'b1;
    end else if (!tick && take) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = (pend_q != '0);

endmodule

// File: rtl/scrub_walker.sv
module scrub_walker #(
  parameter int ROWS  = 64,
  parameter int COLS  = 16,
  parameter int ROW_W = 6,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             row_end,
  output logic             arr_end
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;

  always_comb begin
    row_end = (col_q == COL_LAST);
    arr_end = row_end && (row_q == ROW_LAST);
    row_d   = row_q;
    col_d   = col_q;
    if (adv) begin
      if (row_end) begin
        col_d = '0;
        row_d = arr_end ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (adv) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row = row_q;
  assign col = col_q;

endmodule

// File: rtl/scrub_stats.sv
module scrub_stats #(
  parameter int ROW_W  = 6,
  parameter int TOT_W  = 16,
  parameter int ROWC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_done,
  input  logic              step_err,
  input  logic              row_end,
  input  logic              arr_end,
  input  logic [ROW_W-1:0]  cur_row,
  input  logic [TOT_W-1:0]  total_thresh,
  input  logic [ROWC_W-1:0] row_thresh,
  output logic              pass_done,
  output logic [TOT_W-1:0]  rep_total,
  output logic [ROW_W-1:0]  rep_row,
  output logic [ROWC_W-1:0] rep_row_cnt,
  output logic              rep_row_hit
);

  localparam logic [TOT_W-1:0]  TOT_MAX  = '1;
  localparam logic [ROWC_W-1:0] ROWC_MAX = '1;

  logic [TOT_W-1:0]  tot_q, tot_d, tot_n;
  logic [ROWC_W-1:0] rcnt_q, rcnt_d, rcnt_n;
  logic [ROWC_W-1:0] best_cnt_q, best_cnt_d, best_cnt_n;
  logic [ROW_W-1:0]  best_row_q, best_row_d, best_row_n;
  logic              publish;
  logic              hit_n;
  logic [TOT_W-1:0]  rep_total_d;
  logic [ROW_W-1:0]  rep_row_d;
  logic [ROWC_W-1:0] rep_cnt_d;
  logic              pass_d;

  always_comb begin
    // saturating increments for this step
    tot_n  = (step_err && tot_q  != TOT_MAX)  ? tot_q  + 1'b1 : tot_q;
    rcnt_n = (step_err && rcnt_q != ROWC_MAX) ? rcnt_q + 1'b1 : rcnt_q;

    // worst-row candidate including the row closing now (strict greater)
    best_cnt_n = best_cnt_q;
    best_row_n = best_row_q;
    if (row_end && (rcnt_n > best_cnt_q)) begin
      best_cnt_n = rcnt_n;
      best_row_n = cur_row;
    end

    tot_d      = tot_q;
    rcnt_d     = rcnt_q;
    best_cnt_d = best_cnt_q;
    best_row_d = best_row_q;
    if (step_done) begin
      tot_d      = tot_n;
      rcnt_d     = row_end ? '0 : rcnt_n;
      best_cnt_d = best_cnt_n;
      best_row_d = best_row_n;
      if (arr_end) begin
        tot_d      = '0;
        best_cnt_d = '0;
        best_row_d = '0;
      end
    end

    publish     = step_done && arr_end;
    pass_d      = publish;
    hit_n       = best_cnt_n > row_thresh;
    rep_total_d = (tot_n > total_thresh) ? tot_n : '0;
    rep_row_d   = hit_n ? best_row_n : '0;
    rep_cnt_d   = hit_n ? best_cnt_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q      <= '0;
      rcnt_q     <= '0;
      best_cnt_q <= '0;
      best_row_q <= '0;
    end else if (step_done) begin
      tot_q      <= tot_d;
      rcnt_q     <= rcnt_d;
      best_cnt_q <= best_cnt_d;
      best_row_q <= best_row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_done <= 1'b0;
    end else begin
      pass_done <= pass_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_total   <= '0;
      rep_row     <= '0;
      rep_row_cnt <= '0;
      rep_row_hit <= 1'b0;
    end else if (publish) begin
      rep_total   <= rep_total_d;
      rep_row     <= rep_row_d;
      rep_row_cnt <= rep_cnt_d;
      rep_row_hit <= hit_n;
    end
  end

endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 16,
  parameter int DATA_W = 128,
  parameter int IVL_W  = 32,
  parameter int TOT_W  = 16,
  parameter int ROWC_W = 8,
  parameter int PEND_W = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic              manual_go,
  input  logic [IVL_W-1:0]  step_interval,
  input  logic [TOT_W-1:0]  total_thresh,
  input  logic [ROWC_W-1:0] row_thresh,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ecc_err,
  output logic              pass_done,
  output logic [TOT_W-1:0]  rep_total,
  output logic [ROW_W-1:0]  rep_row,
  output logic [ROWC_W-1:0] rep_row_cnt,
  output logic              rep_row_hit
);

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  step_st_e          st_q, st_d;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;
  logic              start, take, pend;
  logic              step_done, step_err;
  logic              row_end, arr_end;

  always_comb begin
    start     = (st_q == ST_IDLE) && (auto_en ? pend : manual_go);
    take      = start && auto_en;
    st_d      = st_q;
    cap_en    = 1'b0;
    step_done = 1'b0;
    step_err  = 1'b0;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_READ;
      ST_READ: begin
        if (mem_gnt) begin
          if (mem_ecc_err) begin
            cap_en = 1'b1;
            st_d   = ST_WBACK;
          end else begin
            step_done = 1'b1;
            st_d      = ST_IDLE;
          end
        end
      end
      ST_WBACK: begin
        if (mem_gnt) begin
          step_done = 1'b1;
          step_err  = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) data_q <= mem_rdata;
  end

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_wdata = data_q;

  scrub_pacer #(.IVL_W(IVL_W), .PEND_W(PEND_W)) u_pacer (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .auto_en       (auto_en),
    .step_interval (step_interval),
    .take          (take),
    .pend          (pend)
  );

  scrub_walker #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_walker (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .adv     (step_done),
    .row     (mem_row),
    .col     (mem_col),
    .row_end (row_end),
    .arr_end (arr_end)
  );

  scrub_stats #(.ROW_W(ROW_W), .TOT_W(TOT_W), .ROWC_W(ROWC_W)) u_stats (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .step_done    (step_done),
    .step_err     (step_err),
    .row_end      (row_end),
    .arr_end      (arr_end),
    .cur_row      (mem_row),
    .total_thresh (total_thresh),
    .row_thresh   (row_thresh),
    .pass_done    (pass_done),
    .rep_total    (rep_total),
    .rep_row      (rep_row),
    .rep_row_cnt  (rep_row_cnt),
    .rep_row_hit  (rep_row_hit)
  );

endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 4,
  parameter int TOT_W  = 16,
  parameter int ROWC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ROW_W-1:0]  mem_row,
  input logic [COL_W-1:0]  mem_col,
  input logic              mem_gnt,
  input logic              mem_ecc_err,
  input logic              pass_done,
  input logic [TOT_W-1:0]  rep_total,
  input logic [ROW_W-1:0]  rep_row,
  input logic [ROWC_W-1:0] rep_row_cnt,
  input logic              rep_row_hit,
  input logic [TOT_W-1:0]  total_thresh,
  input logic [ROWC_W-1:0] row_thresh
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_idle_in_reset_r1: assert (!mem_req && !pass_done && !rep_row_hit);
    end
  end

  p_pass_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  p_write_needs_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_gnt && mem_ecc_err));

  p_clean_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_gnt && !mem_ecc_err) |=> !mem_we);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_row) && $stable(mem_col)));

  p_total_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (rep_total == '0 || rep_total > total_thresh));

  p_row_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (rep_row_hit == (rep_row_cnt > row_thresh)));

  p_row_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_row_hit |-> (rep_row == '0 && rep_row_cnt == '0));

  p_report_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_done |-> ($stable(rep_total) && $stable(rep_row) && $stable(rep_row_cnt) && $stable(rep_row_hit)));

endmodule

bind scrub_engine scrub_engine_chk #(
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .TOT_W  (TOT_W),
  .ROWC_W (ROWC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_row      (mem_row),
  .mem_col      (mem_col),
  .mem_gnt      (mem_gnt),
  .mem_ecc_err  (mem_ecc_err),
  .pass_done    (pass_done),
  .rep_total    (rep_total),
  .rep_row      (rep_row),
  .rep_row_cnt  (rep_row_cnt),
  .rep_row_hit  (rep_row_hit),
  .total_thresh (total_thresh),
  .row_thresh   (row_thresh)
);

// File: tb/tb_scrub_engine.sv
module tb_scrub_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int NCW  = ROWS * COLS;
  localparam int DW   = 8;
  localparam int TOTMAX = 15;
  localparam int ROWMAX = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          auto_en, manual_go;
  logic [11:0]   step_interval;
  logic [3:0]    total_thresh;
  logic [1:0]    row_thresh;
  logic          mem_req, mem_we, mem_gnt, mem_ecc_err;
  logic [1:0]    mem_row, mem_col;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          pass_done, rep_row_hit;
  logic [3:0]    rep_total;
  logic [1:0]    rep_row, rep_row_cnt;

  logic [NCW-1:0] err_map;

  int checks = 0, errors = 0;
  int cyc = 0, gnt_dly = 0, wcnt = 0;
  int rd_cnt = 0, wr_cnt = 0, exp_addr = 0, last_rd_addr = 0;
  int passes = 0, ival = 0, last_rd_cyc = -1, spacing_bad = 0;
  bit spacing_on = 0, prev_wait = 0, prev_we = 0, done = 0;
  int prev_a = 0;
  int lt_total, lt_row, lt_cnt, lt_hit;
  int e_total, e_row, e_cnt, e_hit;

  always #(CLK_PERIOD/2) clk = ~clk;

  scrub_engine #(
    .ROWS(ROWS), .COLS(COLS), .DATA_W(DW), .IVL_W(12),
    .TOT_W(4), .ROWC_W(2), .PEND_W(4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .manual_go(manual_go),
    .step_interval(step_interval), .total_thresh(total_thresh), .row_thresh(row_thresh),
    .mem_req(mem_req), .mem_we(mem_we), .mem_row(mem_row), .mem_col(mem_col),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_ecc_err(mem_ecc_err), .pass_done(pass_done), .rep_total(rep_total),
    .rep_row(rep_row), .rep_row_cnt(rep_row_cnt), .rep_row_hit(rep_row_hit)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a * 37 + 5);
  endfunction

  assign mem_rdata   = pat({mem_row, mem_col});
  assign mem_ecc_err = err_map[{mem_row, mem_col}];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected pass statistics from the error map (R8, R9)
  task automatic expect_pass(input int tth, input int rth);
    int tot, best, brow;
    tot = 0; best = 0; brow = 0;
    for (int r = 0; r < ROWS; r++) begin
      int c;
      c = 0;
      for (int k = 0; k < COLS; k++) if (err_map[r*COLS+k]) c++;
      tot += c;
      if (c > ROWMAX) c = ROWMAX;
      if (c > best) begin best = c; brow = r; end
    end
    if (tot > TOTMAX) tot = TOTMAX;
    e_total = (tot > tth) ? tot : 0;
    e_hit   = (best > rth) ? 1 : 0;
    e_row   = e_hit ? brow : 0;
    e_cnt   = e_hit ? best : 0;
  endtask

  task automatic check_reports(input string tag);
    chk(lt_total == e_total, {tag, " R8 total"}, lt_total, e_total);
    chk(lt_hit == e_hit, {tag, " R9 hit"}, lt_hit, e_hit);
    chk(lt_row == e_row, {tag, " R9 row"}, lt_row, e_row);
    chk(lt_cnt == e_cnt, {tag, " R9 cnt"}, lt_cnt, e_cnt);
  endtask

  // memory port model and per-access checks
  always @(negedge clk) begin
    int a;
    cyc++;
    a = {mem_row, mem_col};
    if (pass_done) begin
      passes++;
      lt_total = rep_total; lt_row = rep_row; lt_cnt = rep_row_cnt; lt_hit = rep_row_hit;
    end
    if (prev_wait && mem_req)
      chk(a == prev_a && mem_we == prev_we, "R4 held access", a, prev_a);
    prev_wait = 0;
    if (!mem_req) begin
      mem_gnt = 1'b0; wcnt = 0;
    end else if (wcnt >= gnt_dly) begin
      mem_gnt = 1'b1; wcnt = 0;
      if (!mem_we) begin
        rd_cnt++;
        chk(a == exp_addr, "R2 read order", a, exp_addr);
        last_rd_addr = a;
        exp_addr = (exp_addr + 1) % NCW;
        if (spacing_on && last_rd_cyc >= 0 && (cyc - last_rd_cyc) != ival) spacing_bad++;
        last_rd_cyc = cyc;
      end else begin
        wr_cnt++;
        chk(err_map[a] == 1'b1, "R3 write only on error", 0, 1);
        chk(a == last_rd_addr, "R3 write address", a, last_rd_addr);
        chk(mem_wdata == pat(a), "R3 write data", mem_wdata, pat(a));
      end
    end else begin
      mem_gnt = 1'b0; wcnt++;
      prev_wait = 1; prev_a = a; prev_we = mem_we;
    end
  end

  task automatic manual_step();
    @(negedge clk) manual_go = 1'b1;
    @(negedge clk) manual_go = 1'b1;   // second pulse lands while busy (R5)
    @(negedge clk) manual_go = 1'b0;
    while (mem_req) @(negedge clk);
  endtask

  task automatic manual_pass(input string tag, input int dly);
    int rd0, wr0, p0, nerr;
    rd0 = rd_cnt; wr0 = wr_cnt; p0 = passes;
    nerr = $countones(err_map);
    gnt_dly = dly;
    for (int i = 0; i < NCW; i++) manual_step();
    repeat (3) @(negedge clk);
    chk(rd_cnt - rd0 == NCW, {tag, " R5 one step per pulse"}, rd_cnt - rd0, NCW);
    chk(wr_cnt - wr0 == nerr, {tag, " R3 write count"}, wr_cnt - wr0, nerr);
    chk(passes - p0 == 1, {tag, " R2 pass_done once"}, passes - p0, 1);
    expect_pass(total_thresh, row_thresh);
    check_reports(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int rd0, p0;
    rst_n = 1'b0; auto_en = 1'b0; manual_go = 1'b0; mem_gnt = 1'b0;
    step_interval = 12'd4; total_thresh = 4'd3; row_thresh = 2'd2;
    err_map = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(pass_done == 1'b0, "R1 pass_done", pass_done, 0);
    chk(rep_total == 0 && rep_row == 0 && rep_row_cnt == 0 && rep_row_hit == 0,
        "R1 reports", rep_total, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mem_req == 1'b0 && rep_total == 0, "R1 after release", mem_req, 0);

    // pass A: unique worst row, slow grants
    err_map = '0;
    err_map[1*COLS+0] = 1; err_map[1*COLS+3] = 1;
    err_map[2*COLS+0] = 1; err_map[2*COLS+1] = 1; err_map[2*COLS+2] = 1;
    err_map[3*COLS+2] = 1;
    manual_pass("A", 3);

    // pass B: every codeword errored, saturation; reports stable mid-pass (R10)
    err_map = '1;
    gnt_dly = 0;
    for (int i = 0; i < NCW/2; i++) manual_step();
    chk(rep_total == 6 && rep_row == 2 && rep_row_cnt == 3 && rep_row_hit == 1,
        "R10 reports stable mid-pass", rep_total, 6);
    begin
      int rd0b, p0b;
      rd0b = rd_cnt; p0b = passes;
      for (int i = 0; i < NCW/2; i++) manual_step();
      repeat (3) @(negedge clk);
      chk(passes - p0b == 1, "B R2 pass_done once", passes - p0b, 1);
      chk(rd_cnt - rd0b == NCW/2, "B R5 reads", rd_cnt - rd0b, NCW/2);
    end
    expect_pass(total_thresh, row_thresh);
    check_reports("B");

    // pass C: below both thresholds, counts restart (R10)
    err_map = '0;
    err_map[2*COLS+3] = 1; err_map[3*COLS+1] = 1;
    manual_pass("C R10", 1);

    // pass D self-paced: total equals threshold, last row worst; spacing (R6)
    err_map = '0;
    err_map[3*COLS+0] = 1; err_map[3*COLS+1] = 1; err_map[3*COLS+2] = 1;
    gnt_dly = 0; ival = 4; step_interval = 12'd4;
    spacing_on = 1; last_rd_cyc = -1; spacing_bad = 0;
    rd0 = rd_cnt; p0 = passes;
    @(negedge clk) auto_en = 1'b1;
    while (passes == p0) @(negedge clk);
    auto_en = 1'b0; spacing_on = 0;
    repeat (10) @(negedge clk);
    chk(spacing_bad == 0, "R6 step spacing", spacing_bad, 0);
    chk(rd_cnt - rd0 == NCW, "R6 reads in auto pass", rd_cnt - rd0, NCW);
    expect_pass(total_thresh, row_thresh);
    check_reports("D");

    // queued tokens (R7): 10 tokens with slow grants, then no more tokens
    err_map = '0;
    gnt_dly = 5; step_interval = 12'd2;
    rd0 = rd_cnt;
    @(negedge clk) auto_en = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk) step_interval = 12'd1000;
    repeat (200) @(negedge clk);
    chk(rd_cnt - rd0 == 10, "R7 queued steps all run", rd_cnt - rd0, 10);

    // manual pulse ignored in self-paced mode (R5)
    rd0 = rd_cnt;
    @(negedge clk) manual_go = 1'b1;
    @(negedge clk) manual_go = 1'b0;
    repeat (30) @(negedge clk);
    chk(rd_cnt - rd0 == 0, "R5 pulse ignored in auto", rd_cnt - rd0, 0);
    auto_en = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule